// File: doc/BRIEF.md
# Hotplug General-Purpose-Event Controller

This block keeps the general-purpose-event (GPE) status and enable registers of a power-management subsystem and turns slot insertion and removal notifications from the expansion bus into GPE events. A small byte/dword I/O port bus reaches a four-byte GPE window and a sixteen-byte slot window. The slot window holds an inserted-slot bitmap, a removed-slot bitmap, a write-only eject register and a read-only removability mask.

Each hotplug notification rebuilds the two slot bitmaps from scratch, so exactly one slot is ever reported at a time, and sets the hotplug GPE status bit. Notifications flagged as coldplug, for devices already present when the system was built, are dropped without touching any state. The system control interrupt (SCI) output is a level. It is recomputed every cycle from the enabled PM1 sources, which arrive as an input vector, and from the enabled hotplug GPE bit. Firmware clears a status bit, and so drops the level, by writing a 1 to that bit.

Top module: `hpgpe_ctrl`

## Requirements
- R1: After reset all GPE status and enable bits, both slot bitmaps and `eject_o` are zero, and `sci_o` is low while no PM1 source is enabled and pending.
- R2: A dword read at slot-window offset 0xC (default address 0xAE0C) returns, zero-extended, all ones with the bits of `no_hp_mask` cleared. Writes to that offset leave it unchanged.
- R3: The GPE window (default 0xAFE0..0xAFE3) is byte-wide, and reads return the byte in bits 7:0. Offsets 0 and 1 are status bytes, where a written 1 clears the bit and a 0 leaves it. Offsets 2 and 3 are the matching enable bytes and read back what was written.
- R4: A non-coldplug insertion for slot s leaves the inserted bitmap (offset 0x0, default 0xAE00) at exactly 1<<s and the removed bitmap (offset 0x4) at zero, and it sets GPE status bit 1.
- R5: A removal for slot s leaves the removed bitmap at exactly 1<<s and the inserted bitmap at zero, and it sets GPE status bit 1.
- R6: An insertion with `hp_cold` high changes neither bitmap nor any GPE status bit.
- R7: `sci_o` equals the OR of any bit of `pm1_sts & pm1_en` with the AND of GPE status bit 1 and GPE enable bit 1. Other GPE bits do not drive it.
- R8: A dword write at offset 0x8 (default 0xAE08) makes `eject_o` equal the written slot bits for exactly the following cycle, and zero after. Reads of offset 0x8 return zero.
- R9: A hotplug event in the same cycle as a status write that clears bit 1 leaves bit 1 set. An insertion and a removal in the same cycle act as the insertion alone.
- R10: Writes to the two bitmap offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 32 | Write data (bits 7:0 for byte ports) |
| io_rdata | output | 32 | Read data for `io_addr`, combinational |
| pm1_sts | input | PM1_W | Pending PM1 event sources |
| pm1_en | input | PM1_W | PM1 event enables |
| hp_slot | input | SLOT_W | Slot number of the notification |
| hp_insert | input | 1 | Insertion notification strobe |
| hp_remove | input | 1 | Removal notification strobe |
| hp_cold | input | 1 | Marks an insertion as coldplug |
| no_hp_mask | input | NUM_SLOTS | Slots that are not hot-removable |
| eject_o | output | NUM_SLOTS | One-cycle eject request per slot |
| sci_o | output | 1 | Level-sensitive SCI |

## Verification
The bench builds the block with eight slots and a four-bit PM1 vector. With eight slots, every slot number the three-bit `hp_slot` can carry is a real slot, so the one-hot bitmap property and the eject pulse pattern can be checked on the whole port width. A `no_hp_mask` of 0x81 removes the slots at both edges, which lets the removability read show that the clearing is correct at each end of the mask. The narrow PM1 vector is still wide enough to show that a pending source whose enable is off, or an enable whose source is idle, leaves the SCI low.

// File: rtl/hpgpe_pkg.sv
package hpgpe_pkg;

  // GPE status/enable bit carrying slot hotplug events
  localparam int HP_GPE_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GPE,
    SEL_UP,
    SEL_DOWN,
    SEL_EJECT,
    SEL_RMV
  } sel_e;

endpackage

// File: rtl/hpgpe_decode.sv
module hpgpe_decode
  import hpgpe_pkg::*;
#(
  parameter logic [15:0] GPE_BASE = 16'hAFE0,
  parameter logic [15:0] HP_BASE  = 16'hAE00,
  parameter int          GPE_LEN  = 4,
  localparam int         IDX_W    = $clog2(GPE_LEN)
) (
  input  logic [15:0]      addr,
  output sel_e             sel,
  output logic [IDX_W-1:0] byte_idx
);

  logic gpe_hit;
  logic hp_hit;

  always_comb begin
    gpe_hit  = (addr[15:IDX_W] == GPE_BASE[15:IDX_W]);
    hp_hit   = (addr[15:4] == HP_BASE[15:4]) && (addr[1:0] == 2'b00);
    byte_idx = addr[IDX_W-1:0];
    sel      = SEL_NONE;
    if (gpe_hit) begin
      sel = SEL_GPE;
    end else if (hp_hit) begin
      case (addr[3:2])
        2'd0:    sel = SEL_UP;
        2'd1:    sel = SEL_DOWN;
        2'd2:    sel = SEL_EJECT;
        default: sel = SEL_RMV;
      endcase
    end
  end

endmodule

// File: rtl/hpgpe_gpe_regs.sv
module hpgpe_gpe_regs
  import hpgpe_pkg::*;
#(
  parameter int  GPE_LEN = 4,
  localparam int HALF    = GPE_LEN / 2,
  localparam int W       = 8 * HALF,
  localparam int IDX_W   = $clog2(GPE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       wdata,
  input  logic             hp_set,
  output logic [W-1:0]     sts,
  output logic [W-1:0]     en
);

  logic [W-1:0] sts_q, sts_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] clr_mask;
  logic [W-1:0] en_wmask;
  logic         sts_ce, en_ce;

  // one lane per byte of each half of the window
  for (genvar b = 0; b < HALF; b++) begin : g_lane
    assign clr_mask[8*b +: 8] = (wr_en && byte_idx == IDX_W'(b)) ? wdata : 8'h00;
    assign en_wmask[8*b +: 8] = (wr_en && byte_idx == IDX_W'(b + HALF)) ? 8'hFF : 8'h00;
  end

  always_comb begin
    sts_d = sts_q & ~clr_mask;
    if (hp_set) sts_d[HP_GPE_BIT] = 1'b1;
    en_d   = (en_q & ~en_wmask) | ({HALF{wdata}} & en_wmask);
    sts_ce = wr_en || hp_set;
    en_ce  = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      if (sts_ce) sts_q <= sts_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  assign sts = sts_q;
  assign en  = en_q;

endmodule

// File: rtl/hpgpe_slot_regs.sv
module hpgpe_slot_regs #(
  parameter int  NUM_SLOTS = 32,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 ins,
  input  logic                 rem,
  input  logic                 cold,
  input  logic [NUM_SLOTS-1:0] no_hp_mask,
  input  logic                 eject_wr,
  input  logic [NUM_SLOTS-1:0] eject_data,
  output logic [NUM_SLOTS-1:0] up_map,
  output logic [NUM_SLOTS-1:0] down_map,
  output logic [NUM_SLOTS-1:0] rmv_map,
  output logic [NUM_SLOTS-1:0] eject,
  output logic                 hp_set
);

  logic [NUM_SLOTS-1:0] slot_oh;
  logic [NUM_SLOTS-1:0] up_q, up_d, down_q, down_d;
  logic [NUM_SLOTS-1:0] rmv_q, rmv_d, ej_q, ej_d;
  logic                 init_q;
  logic                 evt_ins, evt_any, map_ce, rmv_ce, ej_ce;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
    assign slot_oh[i] = (slot == SLOT_W'(i));
  end

  always_comb begin
    evt_ins = ins && !cold;
    evt_any = evt_ins || rem;
    map_ce  = evt_any;
    if (evt_ins) begin
      up_d   = slot_oh;
      down_d = '0;
    end else begin
      up_d   = '0;
      down_d = slot_oh;
    end
    rmv_ce = !init_q;
    rmv_d  = rmv_q & ~no_hp_mask;
    ej_ce  = eject_wr || (ej_q != '0);
    ej_d   = eject_wr ? eject_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= '0;
      down_q <= '0;
      rmv_q  <= '1;
      init_q <= 1'b0;
      ej_q   <= '0;
    end else begin
      if (map_ce) begin
        up_q   <= up_d;
        down_q <= down_d;
      end
      if (rmv_ce) begin
        rmv_q  <= rmv_d;
        init_q <= 1'b1;
      end
      if (ej_ce) ej_q <= ej_d;
    end
  end

  assign up_map   = up_q;
  assign down_map = down_q;
  assign rmv_map  = rmv_q;
  assign eject    = ej_q;
  assign hp_set   = evt_any;

endmodule

// File: rtl/hpgpe_ctrl.sv
module hpgpe_ctrl
  import hpgpe_pkg::*;
#(
  parameter int          NUM_SLOTS = 32,
  parameter int          PM1_W     = 16,
  parameter logic [15:0] GPE_BASE  = 16'hAFE0,
  parameter logic [15:0] HP_BASE   = 16'hAE00,
  localparam int         GPE_LEN   = 4,
  localparam int         GPE_W     = 8 * GPE_LEN / 2,
  localparam int         IDX_W     = $clog2(GPE_LEN),
  localparam int         SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          io_addr,
  input  logic                 io_wr,
  input  logic [31:0]          io_wdata,
  output logic [31:0]          io_rdata,
  input  logic [PM1_W-1:0]     pm1_sts,
  input  logic [PM1_W-1:0]     pm1_en,
  input  logic [SLOT_W-1:0]    hp_slot,
  input  logic                 hp_insert,
  input  logic                 hp_remove,
  input  logic                 hp_cold,
  input  logic [NUM_SLOTS-1:0] no_hp_mask,
  output logic [NUM_SLOTS-1:0] eject_o,
  output logic                 sci_o
);

  logic                 rst_meta_q, rst_sync_q;
  sel_e                 sel;
  logic [IDX_W-1:0]     byte_idx;
  logic                 gpe_wr, eject_wr, hp_set;
  logic [GPE_W-1:0]     gpe_sts, gpe_en;
  logic [2*GPE_W-1:0]   gpe_bytes;
  logic [NUM_SLOTS-1:0] up_map, down_map, rmv_map;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hpgpe_decode #(
    .GPE_BASE (GPE_BASE),
    .HP_BASE  (HP_BASE),
    .GPE_LEN  (GPE_LEN)
  ) dec_i (
    .addr     (io_addr),
    .sel      (sel),
    .byte_idx (byte_idx)
  );

  assign gpe_wr   = io_wr && (sel == SEL_GPE);
  assign eject_wr = io_wr && (sel == SEL_EJECT);

  hpgpe_gpe_regs #(.GPE_LEN(GPE_LEN)) gpe_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (gpe_wr),
    .byte_idx (byte_idx),
    .wdata    (io_wdata[7:0]),
    .hp_set   (hp_set),
    .sts      (gpe_sts),
    .en       (gpe_en)
  );

  hpgpe_slot_regs #(.NUM_SLOTS(NUM_SLOTS)) slot_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .slot       (hp_slot),
    .ins        (hp_insert),
    .rem        (hp_remove),
    .cold       (hp_cold),
    .no_hp_mask (no_hp_mask),
    .eject_wr   (eject_wr),
    .eject_data (io_wdata[NUM_SLOTS-1:0]),
    .up_map     (up_map),
    .down_map   (down_map),
    .rmv_map    (rmv_map),
    .eject      (eject_o),
    .hp_set     (hp_set)
  );

  assign gpe_bytes = {gpe_en, gpe_sts};

  always_comb begin
    case (sel)
      SEL_GPE:  io_rdata = {24'h0, gpe_bytes[8*byte_idx +: 8]};
      SEL_UP:   io_rdata = 32'(up_map);
      SEL_DOWN: io_rdata = 32'(down_map);
      SEL_RMV:  io_rdata = 32'(rmv_map);
      default:  io_rdata = 32'h0;
    endcase
  end

  assign sci_o = (|(pm1_sts & pm1_en)) ||
                 (gpe_sts[HP_GPE_BIT] && gpe_en[HP_GPE_BIT]);

endmodule

// File: rtl/hpgpe_ctrl_chk.sv
module hpgpe_ctrl_chk #(
  parameter int  NUM_SLOTS = 32,
  parameter int  PM1_W     = 16,
  parameter int  GPE_W     = 16
) (
  input logic                 clk,
  input logic                 rst_sync_q,
  input logic                 io_wr,
  input logic [31:0]          io_wdata,
  input logic                 eject_wr,
  input logic                 gpe_wr,
  input logic                 hp_insert,
  input logic                 hp_remove,
  input logic                 hp_cold,
  input logic                 hp_set,
  input logic [PM1_W-1:0]     pm1_sts,
  input logic [PM1_W-1:0]     pm1_en,
  input logic [GPE_W-1:0]     gpe_sts,
  input logic [GPE_W-1:0]     gpe_en,
  input logic [NUM_SLOTS-1:0] up_map,
  input logic [NUM_SLOTS-1:0] down_map,
  input logic [NUM_SLOTS-1:0] rmv_map,
  input logic [NUM_SLOTS-1:0] eject_o,
  input logic                 sci_o
);

  p_insert_onehot_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (hp_insert && !hp_cold) |=> ($onehot0(up_map) && down_map == '0 && gpe_sts[1]));

  p_remove_map_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (hp_remove && !(hp_insert && !hp_cold)) |=> (up_map == '0 && $onehot0(down_map) && gpe_sts[1]));

  p_cold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (hp_insert && hp_cold && !hp_remove) |=> ($stable(up_map) && $stable(down_map)));

  p_sci_level_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sci_o == ((|(pm1_sts & pm1_en)) || (gpe_sts[1] && gpe_en[1])));

  p_eject_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    eject_wr |=> (eject_o == $past(io_wdata[NUM_SLOTS-1:0])));

  p_eject_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !eject_wr |=> (eject_o == '0));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (hp_set && gpe_wr) |=> gpe_sts[1]);

  p_rmv_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (io_wr && $past(rst_sync_q)) |=> $stable(rmv_map));

endmodule

bind hpgpe_ctrl hpgpe_ctrl_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .PM1_W     (PM1_W),
  .GPE_W     (GPE_W)
) chk_i (
  .clk        (clk),
  .rst_sync_q (rst_sync_q),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .eject_wr   (eject_wr),
  .gpe_wr     (gpe_wr),
  .hp_insert  (hp_insert),
  .hp_remove  (hp_remove),
  .hp_cold    (hp_cold),
  .hp_set     (hp_set),
  .pm1_sts    (pm1_sts),
  .pm1_en     (pm1_en),
  .gpe_sts    (gpe_sts),
  .gpe_en     (gpe_en),
  .up_map     (up_map),
  .down_map   (down_map),
  .rmv_map    (rmv_map),
  .eject_o    (eject_o),
  .sci_o      (sci_o)
);

// File: tb/hpgpe_ctrl_tb_top.sv
module hpgpe_ctrl_tb_top;

  localparam int NS  = 8;
  localparam int PW  = 4;
  localparam int SW  = $clog2(NS);

  localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_INS = 4'd2,
                         OP_REM = 4'd3, OP_COLD = 4'd4, OP_SCI = 4'd5;

  // {req, op, addr, data, expected}
  localparam int NV = 36;
  localparam logic [87:0] VEC [NV] = '{
    {4'd1,  OP_RD,   16'hAFE0, 32'h0,        32'h0},
    {4'd1,  OP_RD,   16'hAE00, 32'h0,        32'h0},
    {4'd2,  OP_RD,   16'hAE0C, 32'h0,        32'h7E},
    {4'd3,  OP_WR,   16'hAFE2, 32'h2,        32'h0},
    {4'd3,  OP_RD,   16'hAFE2, 32'h0,        32'h2},
    {4'd7,  OP_SCI,  16'h0,    32'h0,        32'h0},
    {4'd4,  OP_INS,  16'h0,    32'h3,        32'h0},
    {4'd4,  OP_RD,   16'hAE00, 32'h0,        32'h8},
    {4'd4,  OP_RD,   16'hAE04, 32'h0,        32'h0},
    {4'd4,  OP_RD,   16'hAFE0, 32'h0,        32'h2},
    {4'd7,  OP_SCI,  16'h0,    32'h0,        32'h1},
    {4'd5,  OP_REM,  16'h0,    32'h5,        32'h0},
    {4'd5,  OP_RD,   16'hAE00, 32'h0,        32'h0},
    {4'd5,  OP_RD,   16'hAE04, 32'h0,        32'h20},
    {4'd5,  OP_RD,   16'hAFE0, 32'h0,        32'h2},
    {4'd3,  OP_WR,   16'hAFE0, 32'h2,        32'h0},
    {4'd3,  OP_RD,   16'hAFE0, 32'h0,        32'h0},
    {4'd7,  OP_SCI,  16'h0,    32'h0,        32'h0},
    {4'd6,  OP_COLD, 16'h0,    32'h6,        32'h0},
    {4'd6,  OP_RD,   16'hAE00, 32'h0,        32'h0},
    {4'd6,  OP_RD,   16'hAE04, 32'h0,        32'h20},
    {4'd6,  OP_RD,   16'hAFE0, 32'h0,        32'h0},
    {4'd3,  OP_WR,   16'hAFE2, 32'h0,        32'h0},
    {4'd4,  OP_INS,  16'h0,    32'h0,        32'h0},
    {4'd4,  OP_RD,   16'hAFE0, 32'h0,        32'h2},
    {4'd4,  OP_RD,   16'hAE00, 32'h0,        32'h1},
    {4'd7,  OP_SCI,  16'h0,    32'h0,        32'h0},
    {4'd3,  OP_WR,   16'hAFE3, 32'hA5,       32'h0},
    {4'd3,  OP_RD,   16'hAFE3, 32'h0,        32'hA5},
    {4'd3,  OP_WR,   16'hAFE1, 32'hFF,       32'h0},
    {4'd3,  OP_RD,   16'hAFE1, 32'h0,        32'h0},
    {4'd3,  OP_RD,   16'hAFE0, 32'h0,        32'h2},
    {4'd10, OP_WR,   16'hAE00, 32'hFFFFFFFF, 32'h0},
    {4'd10, OP_RD,   16'hAE00, 32'h0,        32'h1},
    {4'd2,  OP_WR,   16'hAE0C, 32'h0,        32'h0},
    {4'd2,  OP_RD,   16'hAE0C, 32'h0,        32'h7E}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   io_addr;
  logic          io_wr;
  logic [31:0]   io_wdata;
  logic [31:0]   io_rdata;
  logic [PW-1:0] pm1_sts, pm1_en;
  logic [SW-1:0] hp_slot;
  logic          hp_insert, hp_remove, hp_cold;
  logic [NS-1:0] no_hp_mask;
  logic [NS-1:0] eject_o;
  logic          sci_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hpgpe_ctrl #(.NUM_SLOTS(NS), .PM1_W(PW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .pm1_sts    (pm1_sts),
    .pm1_en     (pm1_en),
    .hp_slot    (hp_slot),
    .hp_insert  (hp_insert),
    .hp_remove  (hp_remove),
    .hp_cold    (hp_cold),
    .no_hp_mask (no_hp_mask),
    .eject_o    (eject_o),
    .sci_o      (sci_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wdata = '0;
  endtask

  task automatic bus_read(input string req, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    io_addr = a;
    #1;
    check(req, io_rdata, exp);
  endtask

  task automatic hp_event(input logic ins, input logic rem, input logic cold,
                          input logic [SW-1:0] s);
    @(negedge clk);
    hp_slot = s; hp_insert = ins; hp_remove = rem; hp_cold = cold;
    @(negedge clk);
    hp_insert = 1'b0; hp_remove = 1'b0; hp_cold = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_wdata = '0;
    pm1_sts = '0; pm1_en = '0; hp_slot = '0;
    hp_insert = 1'b0; hp_remove = 1'b0; hp_cold = 1'b0;
    no_hp_mask = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state at the ports
    #1;
    check("R1 eject", 32'(eject_o), 32'h0);
    check("R1 sci", 32'(sci_o), 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [3:0]  rq;
      logic [3:0]  op;
      logic [15:0] a;
      logic [31:0] d, e;
      {rq, op, a, d, e} = VEC[i];
      tag = $sformatf("R%0d vec%0d", rq, i);
      case (op)
        OP_WR:   bus_write(a, d);
        OP_RD:   bus_read(tag, a, e);
        OP_INS:  hp_event(1'b1, 1'b0, 1'b0, SW'(d));
        OP_REM:  hp_event(1'b0, 1'b1, 1'b0, SW'(d));
        OP_COLD: hp_event(1'b1, 1'b0, 1'b1, SW'(d));
        default: begin
          @(negedge clk); #1;
          check(tag, 32'(sci_o), e);
        end
      endcase
    end

    // R8 eject pulse lasts one cycle
    @(negedge clk);
    io_addr = 16'hAE08; io_wdata = 32'h5A; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wdata = '0;
    #1;
    check("R8 eject pulse", 32'(eject_o), 32'h5A);
    @(negedge clk); #1;
    check("R8 eject cleared", 32'(eject_o), 32'h0);
    bus_read("R8 eject read", 16'hAE08, 32'h0);

    // R7 PM1 sources (GPE enable bit 1 is off here)
    @(negedge clk);
    pm1_sts = 4'b0010; pm1_en = 4'b0000; #1;
    check("R7 pm1 masked", 32'(sci_o), 32'h0);
    pm1_en = 4'b0010; #1;
    check("R7 pm1 enabled", 32'(sci_o), 32'h1);
    pm1_en = 4'b0100; #1;
    check("R7 pm1 other", 32'(sci_o), 32'h0);
    pm1_sts = '0; pm1_en = '0;

    // R9 event beats a same-cycle clear of status bit 1
    @(negedge clk);
    io_addr = 16'hAFE0; io_wdata = 32'h2; io_wr = 1'b1;
    hp_slot = 3'd2; hp_insert = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wdata = '0; hp_insert = 1'b0;
    bus_read("R9 status kept", 16'hAFE0, 32'h2);
    bus_read("R9 up map", 16'hAE00, 32'h4);

    // R9 insertion wins over a same-cycle removal
    hp_event(1'b1, 1'b1, 1'b0, 3'd7);
    bus_read("R9 ins wins up", 16'hAE00, 32'h80);
    bus_read("R9 ins wins down", 16'hAE04, 32'h0);

    // R1 a second reset clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_read("R1 status after reset", 16'hAFE0, 32'h0);
    bus_read("R1 enable after reset", 16'hAFE3, 32'h0);
    bus_read("R1 down after reset", 16'hAE04, 32'h0);
    bus_read("R2 mask after reset", 16'hAE0C, 32'h7E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule